// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates a binary number that arrives one bit per clock, least significant bit first, and returns the negated number serially on the same schedule. Every output bit leaves in the same cycle as the input bit it is derived from, so a serial datapath can drop the block in without adding pipeline delay. No adder is used. The machine passes bits through unchanged up to and including the first 1 of the word, then complements every later bit of that word.

A start-of-word strobe, given together with a valid bit, marks the first bit of a new number. That bit is handled as though the machine were in its pass-through state, whatever the previous word left behind. Cycles without a valid bit leave the machine untouched, so a word may be delivered with gaps. The reset style (asynchronous or synchronous, active high) is chosen by a parameter.

Top module: `serial_negator`

## Requirements
- R1: `out_valid` equals `in_valid` in the same cycle.
- R2: After reset the machine is in the pass-through state, so the first valid bit without `sow` is copied to `bit_out`.
- R3: In the pass-through state a valid 0 gives `bit_out` = 0 and keeps the state. A valid 1 gives `bit_out` = 1 and moves the machine to the complement state.
- R4: In the complement state `bit_out` = NOT `bit_in` for every valid bit, and the state stays there until `sow` or reset.
- R5: A valid bit with `sow` = 1 is processed in the pass-through state: `bit_out` = `bit_in`, and the machine enters the complement state only if that bit is 1.
- R6: While `in_valid` = 0, `bit_out` = 0 and the state does not change.
- R7: `sow` with `in_valid` = 0 is ignored. A word already in its complement phase stays there.
- R8: An N-bit word X sent LSB first, with `sow` on its first bit, yields on `bit_out` the N-bit value (2^N - X) mod 2^N, also LSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Reset, active high (async or sync by parameter) |
| in_valid | input | 1 | `bit_in` carries a bit this cycle |
| sow | input | 1 | Marks the first (least significant) bit of a word |
| bit_in | input | 1 | Serial input bit, LSB first |
| out_valid | output | 1 | `bit_out` carries a bit this cycle |
| bit_out | output | 1 | Serial negated bit, same cycle as its input |

## Verification
Every result of this block is due in the cycle its input bit is presented: zero cycles of latency for `bit_out` and `out_valid`. The state change caused by that bit affects only the next valid bit. The bench therefore drives each input on the falling clock edge and samples the outputs one nanosecond later, before the rising edge that commits the state. A check that depends on an earlier bit is made on the following valid bit, after that edge has passed. Idle and ignored-strobe cycles are checked through the output of the next valid bit, which shows whether the complement phase survived.

// File: rtl/negator_pkg.sv
package negator_pkg;

   typedef enum logic {
      ST_COPY   = 1'b0,
      ST_INVERT = 1'b1
   } neg_state_e;

   // Mealy step: output bit for a given state and input bit
   function automatic logic step_out(neg_state_e st, logic b);
      return (st == ST_INVERT) ? ~b : b;
   endfunction

   // Mealy step: state after consuming a bit
   function automatic neg_state_e step_next(neg_state_e st, logic b);
      if (st == ST_INVERT) return ST_INVERT;
      return b ? ST_INVERT : ST_COPY;
   endfunction

endpackage

// File: rtl/negator_state_reg.sv
module negator_state_reg
   import negator_pkg::*;
#(
   parameter int unsigned RESET_ASYNC = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  neg_state_e d,
   output neg_state_e q
);

   if (RESET_ASYNC > 1) begin : g_bad_reset_param
      $error("negator_state_reg: RESET_ASYNC must be 0 or 1");
   end

   if (RESET_ASYNC == 1) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
         if (rst)     q <= ST_COPY;
         else if (en) q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (rst)     q <= ST_COPY;
         else if (en) q <= d;
      end
   end

endmodule

// File: rtl/negator_step.sv
module negator_step
   import negator_pkg::*;
(
   input  neg_state_e cur_state,
   input  logic       in_valid,
   input  logic       sow,
   input  logic       bit_in,
   output logic       bit_out,
   output logic       load_en,
   output neg_state_e nxt_state
);

   neg_state_e eff_state;

   always_comb begin
      // a start-of-word bit is always taken in the pass-through state
      eff_state = (in_valid && sow) ? ST_COPY : cur_state;
      bit_out   = in_valid & step_out(eff_state, bit_in);
      nxt_state = step_next(eff_state, bit_in);
      load_en   = in_valid;
   end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
   import negator_pkg::*;
#(
   parameter int unsigned RESET_ASYNC = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic sow,
   input  logic bit_in,
   output logic out_valid,
   output logic bit_out
);

   neg_state_e state_q;
   neg_state_e state_d;
   logic       load_en;

   negator_step u_step (
      .cur_state (state_q),
      .in_valid  (in_valid),
      .sow       (sow),
      .bit_in    (bit_in),
      .bit_out   (bit_out),
      .load_en   (load_en),
      .nxt_state (state_d)
   );

   negator_state_reg #(
      .RESET_ASYNC (RESET_ASYNC)
   ) u_state (
      .clk (clk),
      .rst (rst),
      .en  (load_en),
      .d   (state_d),
      .q   (state_q)
   );

   assign out_valid = in_valid;

endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk
   import negator_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       sow,
   input logic       bit_in,
   input logic       out_valid,
   input logic       bit_out,
   input neg_state_e state_q
);

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> !bit_out);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> state_q == $past(state_q));

   // R5
   sow_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sow) |-> bit_out == bit_in);

   // R4
   invert_after_one_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sow && $past(in_valid) && $past(bit_in)) |-> bit_out != bit_in);

   // R3
   copy_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && bit_in && bit_out) |=> state_q == ST_INVERT);

endmodule

bind serial_negator serial_negator_chk i_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .sow       (sow),
   .bit_in    (bit_in),
   .out_valid (out_valid),
   .bit_out   (bit_out),
   .state_q   (state_q)
);

// File: tb/test_serial_negator.sv
module test_serial_negator;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic sow = 1'b0;
   logic bit_in = 1'b0;
   logic out_valid;
   logic bit_out;

   int total = 0;
   int bad = 0;
   logic ov, ob;

   always #5 clk = ~clk;

   serial_negator i_serial_negator (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .sow       (sow),
      .bit_in    (bit_in),
      .out_valid (out_valid),
      .bit_out   (bit_out)
   );

   // {input word, expected negation}, 8-bit words (R8)
   localparam logic [15:0] VEC [10] = '{
      {8'h00, 8'h00}, {8'h01, 8'hFF}, {8'h02, 8'hFE}, {8'h80, 8'h80},
      {8'h7F, 8'h81}, {8'hFF, 8'h01}, {8'h2C, 8'hD4}, {8'h10, 8'hF0},
      {8'h55, 8'hAB}, {8'hA0, 8'h60}
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive on falling edge, sample before the next rising edge
   task automatic drive(input logic v, input logic s, input logic b);
      @(negedge clk);
      in_valid = v;
      sow      = s;
      bit_in   = b;
      #1;
      ov = out_valid;
      ob = bit_out;
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] got;
      logic       vall;

      // reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset", {6'd0, out_valid, bit_out}, 8'h00);
      @(negedge clk);
      rst = 1'b0;

      // R2: first bit after reset, no sow, taken in copy state
      drive(1, 0, 1); check("R2 first bit", {7'd0, ob}, 8'h01);
      drive(1, 0, 0); check("R4 after first one", {7'd0, ob}, 8'h01);

      // table walk (R8, R1)
      for (int w = 0; w < 10; w++) begin
         got  = '0;
         vall = 1'b1;
         for (int i = 0; i < 8; i++) begin
            drive(1, (i == 0), VEC[w][8+i]);
            got[i] = ob;
            vall   = vall & ov;
         end
         check("R8 word", got, VEC[w][7:0]);
         check("R1 valid", {7'd0, vall}, 8'h01);
      end

      // R3: zeros pass, first one copied, then complement
      drive(1, 1, 0); check("R3 copy zero", {7'd0, ob}, 8'h00);
      drive(1, 0, 0); check("R3 copy zero", {7'd0, ob}, 8'h00);
      drive(1, 0, 1); check("R3 first one", {7'd0, ob}, 8'h01);
      drive(1, 0, 1); check("R4 invert one", {7'd0, ob}, 8'h00);

      // R6: idle cycle outputs zero and keeps the complement phase
      drive(0, 0, 1); check("R6 idle out", {6'd0, ov, ob}, 8'h00);
      drive(1, 0, 1); check("R6 hold state", {7'd0, ob}, 8'h00);

      // R7: sow without valid is ignored
      drive(0, 1, 1); check("R7 idle sow out", {6'd0, ov, ob}, 8'h00);
      drive(1, 0, 0); check("R7 sow ignored", {7'd0, ob}, 8'h01);

      // R5: sow in the complement phase restarts the word
      drive(1, 1, 0); check("R5 sow zero", {7'd0, ob}, 8'h00);
      drive(1, 0, 0); check("R5 still copy", {7'd0, ob}, 8'h00);
      drive(1, 0, 1); check("R5 copy one", {7'd0, ob}, 8'h01);
      drive(1, 1, 1); check("R5 sow one", {7'd0, ob}, 8'h01);
      drive(1, 0, 1); check("R5 invert after sow one", {7'd0, ob}, 8'h00);

      // R2: reset in the middle of a complement phase
      drive(0, 0, 0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      drive(1, 0, 0); check("R2 reset to copy", {7'd0, ob}, 8'h00);
      drive(1, 0, 1); check("R2 copy one", {7'd0, ob}, 8'h01);
      drive(0, 0, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule